// File: doc/BRIEF.md
# Quarter-Wave Sine Amplitude Reconstructor

This block turns an 8-bit phase word into one 8-bit signed sample of a full sine period. It stores only one quarter of the waveform: 64 unsigned magnitudes covering the rising quarter from 0 to π/2. The two upper phase bits pick the quadrant. The second bit from the top mirrors the table address so the quarter is read backwards. The top bit becomes the sign of the output, and the stored magnitude is negated for the lower half period.

A phase accumulator normally drives the block every clock, and its output feeds a converter. Every phase value maps to the angle (p + 0.5)·2π/256. Because of this half-step offset, no sample falls on a zero crossing, and the four quadrants are exact mirror images of one another. Results leave a two-stage register pipeline.

Top module: `sine_quarter_lut`

## Requirements
- R1: For phase p, the output is round(127·sin((p+0.5)·π/128)) as an 8-bit two's-complement value. The bench accepts an error of at most 1 LSB against a real-valued reference.
- R2: A phase presented before clock edge k appears on `ampOut` after edge k+1, which is a latency of two clocks. A new phase is accepted on every clock.
- R3: Outside reset, bit 7 of `ampOut` equals bit 7 of the phase that produced it (1 = negative half period).
- R4: Within a half period, phase p and phase p XOR 8'h7F give identical outputs, because bit 6 set inverts the 6-bit table address.
- R5: Phase p and phase p XOR 8'h80 give exactly negated outputs.
- R6: The output magnitude always lies between 2 and 127. The value 8'h80 and zero never appear after the pipeline fills.
- R7: While `rstN` is low, `ampOut` is 0.
- R8: Phases 63 and 64 give +127, and phases 191 and 192 give −127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset of the pipeline |
| phaseIn | input | 8 | Phase word, one full turn = 256 |
| ampOut | output | 8 | Signed sine sample, two's complement |

## Verification
The bench walks all 256 phases back-to-back, so a pipeline that is one stage short or long misaligns every sample against the queued reference. Exact mirror and half-turn comparisons catch an address fold that is off by one: a fold using subtraction instead of inversion would break the pairing of p with p XOR 8'h7F. The same comparisons catch a sign restore using one's complement, which would leave the negative half one LSB short. Peak checks at the quadrant boundaries expose a table whose half-step offset is missing. Reset checks confirm that the output is held at zero.

// File: rtl/sine_quad_pkg.sv
package sine_quad_pkg;
  localparam int PHASE_W = 8;
  localparam int AMP_W   = 8;
  localparam int ADDR_W  = PHASE_W - 2;
  localparam int MAG_W   = AMP_W - 1;
  localparam int DEPTH   = 2 ** ADDR_W;

  // strobes from quadrant control to the datapath
  typedef struct packed {
    logic mirror;  // read the quarter in descending order
    logic negate;  // restore negative half period
  } quadCtl_t;
endpackage

// File: rtl/sine_quad_rom.sv
// Quarter-wave magnitude table, values computed at elaboration.
module sine_quad_rom
  import sine_quad_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [MAG_W-1:0]  mag
);
  localparam real HALF_PI = 1.5707963267948966;
  localparam int  FULL    = (1 << MAG_W) - 1;

  function automatic logic [MAG_W-1:0] quarterSample(input int idx);
    real x, x2, s;
    x  = (real'(idx) + 0.5) * HALF_PI / real'(DEPTH);
    x2 = x * x;
    s  = x * (1.0 - x2 / 6.0 * (1.0 - x2 / 20.0 * (1.0 - x2 / 42.0
           * (1.0 - x2 / 72.0 * (1.0 - x2 / 110.0)))));
    return MAG_W'($rtoi(real'(FULL) * s + 0.5));
  endfunction

  logic [MAG_W-1:0] romWord [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic [MAG_W-1:0] ENTRY = quarterSample(i);
    assign romWord[i] = ENTRY;
  end

  assign mag = romWord[addr];
endmodule

// File: rtl/sine_quad_ctrl.sv
// Quadrant decoder: mirror strobe for stage 1, negate strobe aligned to stage 2.
module sine_quad_ctrl
  import sine_quad_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] quadIn,
  output quadCtl_t   ctlS1,
  output quadCtl_t   ctlS2
);
  logic negQ;

  always_comb begin
    ctlS1.mirror = quadIn[0];
    ctlS1.negate = quadIn[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) negQ <= 1'b0;
    else       negQ <= quadIn[1];
  end

  always_comb begin
    ctlS2.mirror = 1'b0;
    ctlS2.negate = negQ;
  end
endmodule

// File: rtl/sine_quad_dp.sv
// Address fold, table read and sign restoration, two register stages.
module sine_quad_dp
  import sine_quad_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] idxIn,
  input  quadCtl_t          ctlS1,
  input  quadCtl_t          ctlS2,
  output logic [AMP_W-1:0]  ampQ
);
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] addrNext;
  logic [MAG_W-1:0]  magRd;
  logic [AMP_W-1:0]  magExt;

  assign addrNext = ctlS1.mirror ? ~idxIn : idxIn;

  always_ff @(posedge clk) begin
    if (!rstN) addrQ <= '0;
    else       addrQ <= addrNext;
  end

  sine_quad_rom u_rom (
    .addr (addrQ),
    .mag  (magRd)
  );

  assign magExt = {1'b0, magRd};

  always_ff @(posedge clk) begin
    if (!rstN) ampQ <= '0;
    else       ampQ <= ctlS2.negate ? (~magExt + 1'b1) : magExt;
  end

  // R6: most negative code never produced
  p_no_min_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    ampQ != {1'b1, {(AMP_W-1){1'b0}}});
endmodule

// File: rtl/sine_quarter_lut.sv
module sine_quarter_lut
  import sine_quad_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] phaseIn,
  output logic [AMP_W-1:0]   ampOut
);
  quadCtl_t ctlS1, ctlS2;

  sine_quad_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .quadIn (phaseIn[PHASE_W-1 -: 2]),
    .ctlS1  (ctlS1),
    .ctlS2  (ctlS2)
  );

  sine_quad_dp u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .idxIn (phaseIn[ADDR_W-1:0]),
    .ctlS1 (ctlS1),
    .ctlS2 (ctlS2),
    .ampQ  (ampOut)
  );

  // edges since reset, saturating, used to qualify checks
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rstN)             warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R3: sign follows phase MSB two clocks back
  p_sign_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2'd2) |-> (ampOut[AMP_W-1] == $past(phaseIn[PHASE_W-1], 2)));

  // R6: never zero once filled
  p_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2'd2) |-> (ampOut != '0));

  // R2: a held phase gives a held sample
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && $past(phaseIn, 2) == $past(phaseIn, 3)) |-> $stable(ampOut));
endmodule

// File: tb/sine_quarter_lut_bench.sv
module sine_quarter_lut_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] phaseIn = '0;
  logic [7:0] ampOut;

  int checks = 0;
  int errors = 0;
  int pending[$];
  int outs[256];
  bit done = 0;

  always #4 clk = ~clk;

  sine_quarter_lut u_sine_quarter_lut (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .ampOut(ampOut)
  );

  function automatic int refVal(int p);
    real v;
    v = 127.0 * $sin((real'(p) + 0.5) * 3.141592653589793 / 128.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic check(string req, int act, int exp, bit ok);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // compare a retired phase against the model; R1 R2 R3
  task automatic retire();
    int p, a, e;
    p = pending.pop_front();
    a = $signed(ampOut);
    e = refVal(p);
    check("R1/R2", a, e, (a - e <= 1) && (e - a <= 1));
    check("R3", int'(ampOut[7]), int'(p[7]), ampOut[7] == p[7]);
    outs[p] = a;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7", $signed(ampOut), 0, ampOut == 8'h00);
    phaseIn = 8'h40;
    @(negedge clk);
    check("R7", $signed(ampOut), 0, ampOut == 8'h00);
    rstN = 1'b1;

    // sweep all phases back to back
    for (int p = 0; p < 256; p++) begin
      if (pending.size() == 2) retire();
      phaseIn = 8'(p);
      pending.push_back(p);
      @(negedge clk);
    end
    while (pending.size() > 0) begin
      if (pending.size() == 2) retire();
      else begin
        @(negedge clk);
        if (pending.size() < 2) retire();
      end
    end

    for (int p = 0; p < 256; p++) begin
      check("R4", outs[p], outs[p ^ 8'h7F], outs[p] == outs[p ^ 8'h7F]);
      check("R5", outs[p], -outs[p ^ 8'h80], outs[p] == -outs[p ^ 8'h80]);
      check("R6", outs[p], 2, (outs[p] >= 2 && outs[p] <= 127) ||
                              (outs[p] <= -2 && outs[p] >= -127));
    end
    check("R8", outs[63], 127, outs[63] == 127);
    check("R8", outs[64], 127, outs[64] == 127);
    check("R8", outs[191], -127, outs[191] == -127);
    check("R8", outs[192], -127, outs[192] == -127);

    // R2: latency of exactly two edges after a step
    phaseIn = 8'd64;
    repeat (3) @(negedge clk);
    phaseIn = 8'd192;
    @(negedge clk);
    check("R2", $signed(ampOut), 127, $signed(ampOut) == 127);
    @(negedge clk);
    check("R2", $signed(ampOut), -127, $signed(ampOut) == -127);

    // R7: reset clears a live output
    rstN = 1'b0;
    @(negedge clk);
    check("R7", $signed(ampOut), 0, ampOut == 8'h00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule